// File: doc/BRIEF.md
# External Bus Port Multiplexer

This block sits between three general-purpose I/O ports and their package pins. It lets the same pins act either as ordinary ports or as an external memory bus. When the bus configuration register enables external bus operation, the first two 8-bit ports together form a 16-bit address bus. Port 0 carries the low byte and port 1 the high byte. The third port becomes an 8-bit bidirectional data bus. Otherwise all three ports pass their own output and direction registers to the pins unchanged.

For each CPU access the block decides what the bus pins show. In normal mode an access that hits on-chip memory is masked: the address and data pins are held at all ones, so nothing internal is visible outside. In trace mode every access is exposed, whether it hits on-chip memory or not. This lets an in-circuit emulator follow internal reads and writes. The data bus floats while PHI2 is low. It drives during PHI2 high for writes and for traced internal cycles. For external reads it stays an input, and the pin value is captured when PHI2 falls. Address decoding into memory blocks and chip selects is done elsewhere.

Top module: `ext_bus_mux`

## Requirements
- R1: External bus operation is selected only when both configuration inputs `cfg_bus_lo` (register bit 0) and `cfg_bus_hi` (register bit 7) are 1. Otherwise each port's pin value equals its output register and each pin enable equals its direction register (1 = output).
- R2: With the bus selected, all sixteen address pin enables are 1. Port 0 carries address bits 7:0 and port 1 carries bits 15:8.
- R3: With the bus selected, trace off and `cpu_onchip`=1, all sixteen address pins are 1.
- R4: With the bus selected, trace off and `cpu_onchip`=1, all eight data pins are driven to 1 (enables all 1) in both PHI2 phases.
- R5: With the bus selected and `cfg_trace`=1, the address pins show `cpu_addr` for every access, on-chip or external.
- R6: With the bus selected, every data pin enable is 0 while PHI2 is low for external accesses and for traced internal accesses.
- R7: During PHI2 high of an external write (`cpu_rd`=0), the data pins drive `cpu_wdata` with all enables 1.
- R8: For an external read, the data pin enables stay 0. At the first clock edge where PHI2 is seen low after being high, `ext_rdata` loads `p2_pin_in`.
- R9: During PHI2 high of a traced internal access, the data pins drive `cpu_wdata` for a write and `int_rdata` for a read, with all enables 1.
- R10: `ext_rdata` is 0 after reset and keeps its value on every edge that is not an external-read PHI2 fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than PHI2 |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus_lo | input | 1 | Bus select bit (configuration bit 0) |
| cfg_bus_hi | input | 1 | Bus select bit (configuration bit 7) |
| cfg_trace | input | 1 | Trace (emulation) mode (configuration bit 3) |
| cpu_addr | input | 16 | CPU access address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_onchip | input | 1 | Access hits on-chip memory |
| int_rdata | input | 8 | Data returned by on-chip memory |
| phi2 | input | 1 | CPU bus phase, high = data phase |
| p0_reg_out | input | 8 | Port 0 output register |
| p0_reg_dir | input | 8 | Port 0 direction register |
| p1_reg_out | input | 8 | Port 1 output register |
| p1_reg_dir | input | 8 | Port 1 direction register |
| p2_reg_out | input | 8 | Port 2 output register |
| p2_reg_dir | input | 8 | Port 2 direction register |
| p2_pin_in | input | 8 | Port 2 pin input value |
| p0_pin_out | output | 8 | Port 0 pin value |
| p0_pin_oe | output | 8 | Port 0 pin enables |
| p1_pin_out | output | 8 | Port 1 pin value |
| p1_pin_oe | output | 8 | Port 1 pin enables |
| p2_pin_out | output | 8 | Port 2 pin value |
| p2_pin_oe | output | 8 | Port 2 pin enables |
| ext_rdata | output | 8 | Data captured from an external read |

## Verification
The assertions assume that `phi2` is synchronous to `clk` and stays in each phase for at least one clock. They also assume that the access qualifiers (`cpu_rd`, `cpu_onchip`, configuration) are held steady across the PHI2 falling edge of a cycle, so that the capture decision sees the access it belongs to. The bench changes every input only at the falling clock edge. It holds PHI2 high for a full clock before dropping it, and keeps the access attributes stable through the capture edge. Combinational pin values are checked one time unit after each change.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

   // Classification of the current access as seen by the pins
   typedef enum logic [1:0] {
      ACC_PORT   = 2'd0,   // bus not selected: plain port pass-through
      ACC_HIDDEN = 2'd1,   // on-chip hit in normal mode: masked with ones
      ACC_EXT    = 2'd2,   // external memory cycle
      ACC_TRACE  = 2'd3    // on-chip hit exposed in trace mode
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic sel_lo,
                                          input logic sel_hi,
                                          input logic trace,
                                          input logic onchip);
      if (!(sel_lo && sel_hi)) return ACC_PORT;
      if (!onchip)             return ACC_EXT;
      if (trace)               return ACC_TRACE;
      return ACC_HIDDEN;
   endfunction

endpackage

// File: rtl/bus_access_decode.sv
module bus_access_decode
   import ext_bus_pkg::*;
(
   input  logic      sel_lo,
   input  logic      sel_hi,
   input  logic      trace,
   input  logic      onchip,
   output acc_kind_e kind
);

   always_comb begin
      kind = classify(sel_lo, sel_hi, trace, onchip);
   end

endmodule

// File: rtl/addr_pin_mux.sv
module addr_pin_mux
   import ext_bus_pkg::*;
#(
   parameter int PORT_W  = 8,
   parameter int N_PORTS = 2,
   localparam int ADDR_W = PORT_W * N_PORTS
)(
   input  acc_kind_e                      kind,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [N_PORTS-1:0][PORT_W-1:0] reg_out,
   input  logic [N_PORTS-1:0][PORT_W-1:0] reg_dir,
   output logic [N_PORTS-1:0][PORT_W-1:0] pin_out,
   output logic [N_PORTS-1:0][PORT_W-1:0] pin_oe
);

   if (PORT_W < 1) begin : g_bad_width
      $error("addr_pin_mux: PORT_W must be at least 1");
   end
   if (N_PORTS < 1) begin : g_bad_ports
      $error("addr_pin_mux: N_PORTS must be at least 1");
   end

   // Each port carries one byte lane of the address, lowest lane on port 0
   for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
      always_comb begin
         unique case (kind)
            ACC_PORT: begin
               pin_out[g] = reg_out[g];
               pin_oe[g]  = reg_dir[g];
            end
            ACC_HIDDEN: begin
               pin_out[g] = '1;
               pin_oe[g]  = '1;
            end
            default: begin
               pin_out[g] = addr[g*PORT_W +: PORT_W];
               pin_oe[g]  = '1;
            end
         endcase
      end
   end

endmodule

// File: rtl/data_pin_mux.sv
module data_pin_mux
   import ext_bus_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  acc_kind_e         kind,
   input  logic              phi2,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] int_rdata,
   input  logic [DATA_W-1:0] reg_out,
   input  logic [DATA_W-1:0] reg_dir,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe
);

   if (DATA_W < 1) begin : g_bad_width
      $error("data_pin_mux: DATA_W must be at least 1");
   end

   always_comb begin
      pin_out = '0;
      pin_oe  = '0;
      unique case (kind)
         ACC_PORT: begin
            pin_out = reg_out;
            pin_oe  = reg_dir;
         end
         ACC_HIDDEN: begin
            pin_out = '1;
            pin_oe  = '1;
         end
         ACC_EXT: begin
            if (phi2 && !rd) begin
               pin_out = wdata;
               pin_oe  = '1;
            end
         end
         ACC_TRACE: begin
            if (phi2) begin
               pin_out = rd ? int_rdata : wdata;
               pin_oe  = '1;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/read_capture.sv
module read_capture
   import ext_bus_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic              rd,
   input  logic              phi2,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] rdata
);

   logic phi2_q;
   logic take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phi2_q <= 1'b0;
      else        phi2_q <= phi2;
   end

   assign take = (kind == ACC_EXT) && rd && phi2_q && !phi2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata <= '0;
      else if (take) rdata <= pin_in;
   end

   // R8: a PHI2 fall of an external read loads the pin value
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> rdata == $past(pin_in));

   // R10: captured data holds on every other edge
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(rdata));

endmodule

// File: rtl/ext_bus_mux.sv
module ext_bus_mux
   import ext_bus_pkg::*;
#(
   parameter int PORT_W  = 8,
   parameter int N_ADDR  = 2,
   localparam int ADDR_W = PORT_W * N_ADDR
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bus_lo,
   input  logic              cfg_bus_hi,
   input  logic              cfg_trace,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [PORT_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_onchip,
   input  logic [PORT_W-1:0] int_rdata,
   input  logic              phi2,
   input  logic [PORT_W-1:0] p0_reg_out,
   input  logic [PORT_W-1:0] p0_reg_dir,
   input  logic [PORT_W-1:0] p1_reg_out,
   input  logic [PORT_W-1:0] p1_reg_dir,
   input  logic [PORT_W-1:0] p2_reg_out,
   input  logic [PORT_W-1:0] p2_reg_dir,
   input  logic [PORT_W-1:0] p2_pin_in,
   output logic [PORT_W-1:0] p0_pin_out,
   output logic [PORT_W-1:0] p0_pin_oe,
   output logic [PORT_W-1:0] p1_pin_out,
   output logic [PORT_W-1:0] p1_pin_oe,
   output logic [PORT_W-1:0] p2_pin_out,
   output logic [PORT_W-1:0] p2_pin_oe,
   output logic [PORT_W-1:0] ext_rdata
);

   if (N_ADDR != 2) begin : g_bad_addr
      $error("ext_bus_mux: the address bus spans exactly two ports");
   end

   acc_kind_e                     kind;
   logic [N_ADDR-1:0][PORT_W-1:0] a_reg_out, a_reg_dir, a_pin_out, a_pin_oe;
   logic                          bus_on;

   assign bus_on    = cfg_bus_lo && cfg_bus_hi;
   assign a_reg_out = {p1_reg_out, p0_reg_out};
   assign a_reg_dir = {p1_reg_dir, p0_reg_dir};

   bus_access_decode u_decode (
      .sel_lo (cfg_bus_lo),
      .sel_hi (cfg_bus_hi),
      .trace  (cfg_trace),
      .onchip (cpu_onchip),
      .kind   (kind)
   );

   addr_pin_mux #(.PORT_W(PORT_W), .N_PORTS(N_ADDR)) u_addr (
      .kind    (kind),
      .addr    (cpu_addr),
      .reg_out (a_reg_out),
      .reg_dir (a_reg_dir),
      .pin_out (a_pin_out),
      .pin_oe  (a_pin_oe)
   );

   assign p0_pin_out = a_pin_out[0];
   assign p0_pin_oe  = a_pin_oe[0];
   assign p1_pin_out = a_pin_out[1];
   assign p1_pin_oe  = a_pin_oe[1];

   data_pin_mux #(.DATA_W(PORT_W)) u_data (
      .kind      (kind),
      .phi2      (phi2),
      .rd        (cpu_rd),
      .wdata     (cpu_wdata),
      .int_rdata (int_rdata),
      .reg_out   (p2_reg_out),
      .reg_dir   (p2_reg_dir),
      .pin_out   (p2_pin_out),
      .pin_oe    (p2_pin_oe)
   );

   read_capture #(.DATA_W(PORT_W)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind   (kind),
      .rd     (cpu_rd),
      .phi2   (phi2),
      .pin_in (p2_pin_in),
      .rdata  (ext_rdata)
   );

   // R1: without both select bits the ports pass through
   a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_on |-> (p2_pin_out == p2_reg_out && p2_pin_oe == p2_reg_dir
                   && p0_pin_oe == p0_reg_dir && p1_pin_oe == p1_reg_dir));

   // R2: address pins always drive in bus mode
   a_r2_addr_drive: assert property (@(posedge clk) disable iff (!rst_n)
      bus_on |-> (&{p1_pin_oe, p0_pin_oe}));

   // R3/R4: masked on-chip access shows ones everywhere
   a_r3_hide: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && !cfg_trace && cpu_onchip)
         |-> (&{p1_pin_out, p0_pin_out, p2_pin_out, p2_pin_oe}));

   // R5: trace mode exposes the real address
   a_r5_trace_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && cfg_trace) |-> {p1_pin_out, p0_pin_out} == cpu_addr);

   // R6: data bus floats in PHI2 low unless the access is masked
   a_r6_float: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && !phi2 && !(cpu_onchip && !cfg_trace)) |-> p2_pin_oe == '0);

   // R7: external write drives write data in PHI2 high
   a_r7_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && !cpu_onchip && phi2 && !cpu_rd)
         |-> (p2_pin_out == cpu_wdata && (&p2_pin_oe)));

   // R8: external read never drives the data pins
   a_r8_read_float: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && !cpu_onchip && cpu_rd) |-> p2_pin_oe == '0);

   // R9: traced internal read shows on-chip data in PHI2 high
   a_r9_trace_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && cfg_trace && cpu_onchip && phi2 && cpu_rd)
         |-> p2_pin_out == int_rdata);

endmodule

// File: tb/ext_bus_mux_tb.sv
module ext_bus_mux_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bus_lo = 1'b0, cfg_bus_hi = 1'b0, cfg_trace = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0, int_rdata = '0, p2_pin_in = '0;
   logic        cpu_rd = 1'b1, cpu_onchip = 1'b0, phi2 = 1'b0;
   logic [7:0]  p0_reg_out = 8'h5A, p0_reg_dir = 8'h0F;
   logic [7:0]  p1_reg_out = 8'hC3, p1_reg_dir = 8'hF0;
   logic [7:0]  p2_reg_out = 8'h96, p2_reg_dir = 8'h33;
   logic [7:0]  p0_pin_out, p0_pin_oe, p1_pin_out, p1_pin_oe;
   logic [7:0]  p2_pin_out, p2_pin_oe, ext_rdata;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   ext_bus_mux u_dut (.*);

   typedef struct packed {
      logic [2:0]  cfg;     // {hi(bit7), trace(bit3), lo(bit0)}
      logic [15:0] addr;
      logic [7:0]  wd;
      logic        rd;
      logic        onchip;
      logic        ph;
      logic [7:0]  ird;
      logic [15:0] ea;      // expected {p1,p0} pin value
      logic [15:0] eaoe;    // expected {p1,p0} enables
      logic [7:0]  ed;      // expected data pins (checked only if enabled)
      logic [7:0]  edoe;    // expected data enables
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      // R1: bus off, ports pass through
      '{3'b000, 16'h1234, 8'h11, 1'b1, 1'b0, 1'b1, 8'h00, 16'hC35A, 16'hF00F, 8'h96, 8'h33},
      // R1: only bit 7 set still passes through
      '{3'b100, 16'h1234, 8'h11, 1'b0, 1'b0, 1'b1, 8'h00, 16'hC35A, 16'hF00F, 8'h96, 8'h33},
      // R1: only bit 0 set still passes through
      '{3'b001, 16'h1234, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 16'hC35A, 16'hF00F, 8'h96, 8'h33},
      // R3 R4: normal on-chip read, PHI2 high
      '{3'b101, 16'h1234, 8'h11, 1'b1, 1'b1, 1'b1, 8'hE1, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF},
      // R3 R4: normal on-chip write, PHI2 low
      '{3'b101, 16'h0200, 8'h22, 1'b0, 1'b1, 1'b0, 8'h00, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF},
      // R2 R7: external write, PHI2 high
      '{3'b101, 16'hABCD, 8'h3C, 1'b0, 1'b0, 1'b1, 8'h00, 16'hABCD, 16'hFFFF, 8'h3C, 8'hFF},
      // R6: external write, PHI2 low
      '{3'b101, 16'hABCD, 8'h3C, 1'b0, 1'b0, 1'b0, 8'h00, 16'hABCD, 16'hFFFF, 8'h00, 8'h00},
      // R8: external read, PHI2 high floats
      '{3'b101, 16'h8001, 8'h3C, 1'b1, 1'b0, 1'b1, 8'h00, 16'h8001, 16'hFFFF, 8'h00, 8'h00},
      // R5 R9: traced on-chip write, PHI2 high
      '{3'b111, 16'h0042, 8'h77, 1'b0, 1'b1, 1'b1, 8'hE1, 16'h0042, 16'hFFFF, 8'h77, 8'hFF},
      // R5 R9: traced on-chip read, PHI2 high
      '{3'b111, 16'h0042, 8'h77, 1'b1, 1'b1, 1'b1, 8'hE1, 16'h0042, 16'hFFFF, 8'hE1, 8'hFF},
      // R5 R6: traced on-chip read, PHI2 low floats
      '{3'b111, 16'h0042, 8'h77, 1'b1, 1'b1, 1'b0, 8'hE1, 16'h0042, 16'hFFFF, 8'h00, 8'h00},
      // R5 R7: traced external write, PHI2 high
      '{3'b111, 16'hFEDC, 8'h5B, 1'b0, 1'b0, 1'b1, 8'h00, 16'hFEDC, 16'hFFFF, 8'h5B, 8'hFF}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [2:0] c);
      cfg_bus_hi = c[2];
      cfg_trace  = c[1];
      cfg_bus_lo = c[0];
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      // Reset state (R10)
      repeat (3) @(negedge clk);
      #1 check("R10 reset", {8'h0, ext_rdata}, 16'h0000);
      rst_n = 1'b1;

      // Vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         set_cfg(VEC[i].cfg);
         cpu_addr   = VEC[i].addr;
         cpu_wdata  = VEC[i].wd;
         cpu_rd     = VEC[i].rd;
         cpu_onchip = VEC[i].onchip;
         phi2       = VEC[i].ph;
         int_rdata  = VEC[i].ird;
         #1;
         check("R1/R2/R3/R5 addr", {p1_pin_out, p0_pin_out}, VEC[i].ea);
         check("R1/R2 addr oe", {p1_pin_oe, p0_pin_oe}, VEC[i].eaoe);
         check("R4/R6/R7/R8/R9 data oe", {8'h0, p2_pin_oe}, {8'h0, VEC[i].edoe});
         if (VEC[i].edoe != 8'h00)
            check("R4/R7/R9 data", {8'h0, p2_pin_out}, {8'h0, VEC[i].ed});
      end

      // R8: external read capture at PHI2 fall
      @(negedge clk);
      set_cfg(3'b101);
      cpu_addr = 16'h9000; cpu_rd = 1'b1; cpu_onchip = 1'b0;
      phi2 = 1'b1; p2_pin_in = 8'hA5;
      @(negedge clk);
      #1 check("R10 hold before fall", {8'h0, ext_rdata}, 16'h0000);
      @(negedge clk);
      phi2 = 1'b0;
      @(negedge clk);
      #1 check("R8 capture", {8'h0, ext_rdata}, 16'h00A5);
      p2_pin_in = 8'h3E;
      @(negedge clk);
      #1 check("R10 no recapture in PHI2 low", {8'h0, ext_rdata}, 16'h00A5);

      // R10: external write PHI2 fall leaves capture untouched
      cpu_rd = 1'b0; phi2 = 1'b1;
      @(negedge clk); phi2 = 1'b0;
      @(negedge clk);
      #1 check("R10 write fall", {8'h0, ext_rdata}, 16'h00A5);

      // R10: masked on-chip read PHI2 fall leaves capture untouched
      cpu_rd = 1'b1; cpu_onchip = 1'b1; phi2 = 1'b1;
      @(negedge clk); phi2 = 1'b0;
      @(negedge clk);
      #1 check("R10 on-chip read fall", {8'h0, ext_rdata}, 16'h00A5);

      // R8: traced external read also captures
      set_cfg(3'b111); cpu_onchip = 1'b0; p2_pin_in = 8'h69; phi2 = 1'b1;
      #1 check("R8 read oe in trace", {8'h0, p2_pin_oe}, 16'h0000);
      @(negedge clk); phi2 = 1'b0;
      @(negedge clk);
      #1 check("R8 traced external capture", {8'h0, ext_rdata}, 16'h0069);

      // R1: changed port registers follow through when bus off
      set_cfg(3'b000); p0_reg_out = 8'h81; p2_reg_dir = 8'hC0;
      #1;
      check("R1 port0 follow", {8'h0, p0_pin_out}, 16'h0081);
      check("R1 port2 dir follow", {8'h0, p2_pin_oe}, 16'h00C0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule